// File: doc/BRIEF.md
# Three-Axis Sample Buffer with Selectable Queue Modes

This block queues up to 32 three-axis sample sets (X, Y and Z together) between a sensor datapath that produces one set per output period and a host that drains one set per read request. A control byte chooses how the queue behaves when it fills. It can hand the newest set straight through. It can stop accepting sets once full. It can keep the newest 32 by discarding the oldest. It can also discard the oldest only until a selected trigger fires, and after that keep its contents fixed.

A status byte reports the number of stored sets, a full indication, a watermark flag and an overrun flag. The watermark and overrun flags are also driven on dedicated outputs. The read port presents the oldest stored set combinationally, and a read request removes it. An enable input must be high for the queue to be used at all. When it is low, the block acts as in bypass.

Top module: `sample_fifo`

## Requirements
- R1: After reset the status byte is 0x00, both flag outputs are low and no set is stored.
- R2: Control byte bits 7:6 select the mode (00 bypass, 01 stop-when-full, 10 stream, 11 stream-then-freeze). Bit 5 picks which trigger input line is used (0 selects trig_in[0], 1 selects trig_in[1]). Bits 4:0 hold the watermark threshold.
- R3: Status byte bit 7 is the watermark flag and bit 6 is the overrun flag. Bit 5 is high when all 32 entries are stored. Bits 4:0 give the stored count, saturating at 31.
- R4: While buf_en is low, the block behaves as in bypass, whatever mode the control byte selects.
- R5: In bypass, the queue is emptied and the overrun flag is cleared. The read port shows the most recently written set, and rd_avail is high once any set has been written.
- R6: In stop-when-full mode, sets are read back oldest first. A write arriving while 32 sets are stored is discarded, and the overrun flag is set.
- R7: In stream mode, a write arriving while 32 sets are stored (with no read in that cycle) discards the oldest set. The count stays at 32 and the overrun flag is set.
- R8: In stream-then-freeze mode, the queue behaves as stream until the selected trigger line is seen high, and as stop-when-full from the next cycle on. Leaving the mode forgets the trigger.
- R9: The watermark flag is high exactly when the stored count is greater than the threshold, and it follows the count down as sets are read.
- R10: A read that removes a set clears the overrun flag, unless the same cycle raises a new overrun.
- R11: A write and a read in the same cycle on a full queue both take effect in any non-bypass mode. The count stays at 32 and no overrun is raised.
- R12: A read request while the queue is empty changes nothing: the count stays at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_ctrl | input | 8 | Control byte: mode, trigger select, watermark threshold |
| buf_en | input | 1 | Queue enable; low forces bypass behaviour |
| trig_in | input | 2 | Two candidate trigger lines for stream-then-freeze |
| wr_valid | input | 1 | A new sample set is offered this cycle |
| wr_x | input | 16 | X value of the offered set |
| wr_y | input | 16 | Y value of the offered set |
| wr_z | input | 16 | Z value of the offered set |
| rd_req | input | 1 | Host read request; pops the oldest set |
| rd_x | output | 16 | X value of the set at the read port |
| rd_y | output | 16 | Y value of the set at the read port |
| rd_z | output | 16 | Z value of the set at the read port |
| rd_avail | output | 1 | The read port holds a valid set |
| status | output | 8 | Status byte |
| wtm_flag | output | 1 | Watermark flag |
| ovr_flag | output | 1 | Overrun flag |

## Verification
The cycle that matters most is one where a write and a read arrive together on a full queue. In stream mode the write would otherwise discard the oldest set, and in stop-when-full mode it would otherwise be refused. The bench first fills the queue in stream mode past capacity so that the overrun flag is already set. It then offers a write and a read in the same cycle. The result passes if the count still reads 32 and the next oldest set appears at the read port. It also passes only if the overrun flag has dropped, because the read wins over any overrun. The trigger arriving in stream-then-freeze mode is judged the same way, by watching whether the next write at full discards the head or is refused.

// File: rtl/sfifo_pkg.sv
package sfifo_pkg;

  typedef enum logic [1:0] {
    MODE_BYPASS = 2'b00,
    MODE_FIFO   = 2'b01,
    MODE_STREAM = 2'b10,
    MODE_S2F    = 2'b11
  } sf_mode_e;

  // Count shown in the status byte: saturates at the top of a 5-bit field.
  function automatic logic [4:0] count_field(input int unsigned cnt);
    return (cnt > 31) ? 5'd31 : 5'(cnt);
  endfunction

  function automatic logic wm_hit(input int unsigned cnt, input logic [4:0] thr);
    return cnt > int'(thr);
  endfunction

  function automatic int unsigned next_fill(input int unsigned cnt,
                                            input logic grow, input logic shrink);
    return cnt + (grow ? 1 : 0) - (shrink ? 1 : 0);
  endfunction

endpackage

// File: rtl/sf_ctrl.sv
module sf_ctrl
  import sfifo_pkg::*;
#(
  parameter int DEPTH = 32,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [7:0]    cfg_ctrl,
  input  logic          buf_en,
  input  logic [1:0]    trig_in,
  input  logic          wr_valid,
  input  logic          rd_req,
  output logic          push,
  output logic          pop,
  output logic          drop,
  output logic          ovr_evt,
  output logic          is_bypass,
  output logic          is_frozen,
  output logic          is_stream,
  output logic [CW-1:0] fill_cnt,
  output logic          ovr_q,
  output logic          wtm,
  output logic [7:0]    status
);

  sf_mode_e   eff_mode;
  logic [4:0] thr;
  logic       trig_sel;
  logic       trig_seen;
  logic       full;
  logic       empty;

  assign eff_mode = buf_en ? sf_mode_e'(cfg_ctrl[7:6]) : MODE_BYPASS;
  assign trig_sel = cfg_ctrl[5];
  assign thr      = cfg_ctrl[4:0];

  assign is_bypass = (eff_mode == MODE_BYPASS);
  assign is_frozen = (eff_mode == MODE_FIFO) || ((eff_mode == MODE_S2F) && trig_seen);
  assign is_stream = (eff_mode == MODE_STREAM) || ((eff_mode == MODE_S2F) && !trig_seen);

  assign full  = (fill_cnt == CW'(DEPTH));
  assign empty = (fill_cnt == '0);

  assign pop     = rd_req && !empty && !is_bypass;
  assign ovr_evt = wr_valid && !is_bypass && full && !pop;
  assign push    = wr_valid && !is_bypass && (!full || pop || is_stream);
  assign drop    = wr_valid && is_stream && full && !pop;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fill_cnt  <= '0;
      ovr_q     <= 1'b0;
      trig_seen <= 1'b0;
    end else begin
      if (is_bypass) fill_cnt <= '0;
      else           fill_cnt <= CW'(next_fill(int'(fill_cnt), push, pop || drop));

      if (is_bypass)    ovr_q <= 1'b0;
      else if (ovr_evt) ovr_q <= 1'b1;
      else if (pop)     ovr_q <= 1'b0;

      trig_seen <= (eff_mode == MODE_S2F) && (trig_seen || trig_in[trig_sel]);
    end
  end

  assign wtm    = wm_hit(int'(fill_cnt), thr);
  assign status = {wtm, ovr_q, full, count_field(int'(fill_cnt))};

endmodule

// File: rtl/sf_store.sv
module sf_store #(
  parameter int DEPTH = 32,
  parameter int DW    = 16,
  parameter int NAX   = 3,
  localparam int PW   = $clog2(DEPTH)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    clear,
  input  logic                    push,
  input  logic                    advance,
  input  logic [NAX-1:0][DW-1:0]  wr_set,
  output logic [NAX-1:0][DW-1:0]  head_set
);

  logic [PW-1:0] wr_ptr;
  logic [PW-1:0] rd_ptr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
    end else if (clear) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
    end else begin
      if (push)    wr_ptr <= wr_ptr + 1'b1;
      if (advance) rd_ptr <= rd_ptr + 1'b1;
    end
  end

  for (genvar a = 0; a < NAX; a++) begin : g_axis
    logic [DW-1:0] mem [DEPTH];
    always_ff @(posedge clk) begin
      if (push && !clear) mem[wr_ptr] <= wr_set[a];
    end
    assign head_set[a] = mem[rd_ptr];
  end

endmodule

// File: rtl/sf_hold.sv
module sf_hold #(
  parameter int DW  = 16,
  parameter int NAX = 3
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   load,
  input  logic [NAX-1:0][DW-1:0] din,
  output logic [NAX-1:0][DW-1:0] dout,
  output logic                   dvalid
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dout   <= '0;
      dvalid <= 1'b0;
    end else if (load) begin
      dout   <= din;
      dvalid <= 1'b1;
    end
  end

endmodule

// File: rtl/sample_fifo.sv
module sample_fifo #(
  parameter int DEPTH = 32,
  parameter int DW    = 16,
  localparam int CW   = $clog2(DEPTH + 1),
  localparam int NAX  = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [7:0]    cfg_ctrl,
  input  logic          buf_en,
  input  logic [1:0]    trig_in,
  input  logic          wr_valid,
  input  logic [DW-1:0] wr_x,
  input  logic [DW-1:0] wr_y,
  input  logic [DW-1:0] wr_z,
  input  logic          rd_req,
  output logic [DW-1:0] rd_x,
  output logic [DW-1:0] rd_y,
  output logic [DW-1:0] rd_z,
  output logic          rd_avail,
  output logic [7:0]    status,
  output logic          wtm_flag,
  output logic          ovr_flag
);

  logic          push, pop, drop, ovr_evt;
  logic          is_bypass, is_frozen, is_stream;
  logic [CW-1:0] fill_cnt;
  logic          hold_valid;
  logic [NAX-1:0][DW-1:0] in_set, head_set, hold_set, out_set;

  assign in_set = {wr_z, wr_y, wr_x};

  sf_ctrl #(.DEPTH(DEPTH)) i_ctrl (
    .clk(clk), .rst_n(rst_n), .cfg_ctrl(cfg_ctrl), .buf_en(buf_en),
    .trig_in(trig_in), .wr_valid(wr_valid), .rd_req(rd_req),
    .push(push), .pop(pop), .drop(drop), .ovr_evt(ovr_evt),
    .is_bypass(is_bypass), .is_frozen(is_frozen), .is_stream(is_stream),
    .fill_cnt(fill_cnt), .ovr_q(ovr_flag), .wtm(wtm_flag), .status(status)
  );

  sf_store #(.DEPTH(DEPTH), .DW(DW), .NAX(NAX)) i_store (
    .clk(clk), .rst_n(rst_n), .clear(is_bypass), .push(push),
    .advance(pop || drop), .wr_set(in_set), .head_set(head_set)
  );

  sf_hold #(.DW(DW), .NAX(NAX)) i_hold (
    .clk(clk), .rst_n(rst_n), .load(wr_valid && is_bypass),
    .din(in_set), .dout(hold_set), .dvalid(hold_valid)
  );

  assign out_set  = is_bypass ? hold_set : head_set;
  assign rd_x     = out_set[0];
  assign rd_y     = out_set[1];
  assign rd_z     = out_set[2];
  assign rd_avail = is_bypass ? hold_valid : (fill_cnt != '0);

endmodule

// File: rtl/sample_fifo_chk.sv
module sample_fifo_chk #(
  parameter int DEPTH = 32,
  parameter int CW    = 6
) (
  input logic          clk,
  input logic          rst_n,
  input logic [7:0]    cfg_ctrl,
  input logic          buf_en,
  input logic          wr_valid,
  input logic          rd_req,
  input logic          is_bypass,
  input logic          is_frozen,
  input logic          is_stream,
  input logic [CW-1:0] fill_cnt,
  input logic          ovr_flag
);

  logic full;
  logic in_s2f;
  assign full   = (fill_cnt == CW'(DEPTH));
  assign in_s2f = buf_en && (cfg_ctrl[7:6] == 2'b11);

  p_count_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
    fill_cnt <= CW'(DEPTH));

  p_bypass_clears_r5: assert property (@(posedge clk) disable iff (!rst_n)
    is_bypass |=> (fill_cnt == '0) && !ovr_flag);

  p_frozen_refuse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (is_frozen && full && wr_valid && !rd_req) |=> full && ovr_flag);

  p_stream_discard_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (is_stream && full && wr_valid && !rd_req) |=> full && ovr_flag);

  p_trigger_sticks_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (is_frozen && in_s2f) |=> (!in_s2f || is_frozen));

  p_full_both_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (!is_bypass && full && wr_valid && rd_req) |=> full && !ovr_flag);

  p_empty_read_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (!is_bypass && fill_cnt == '0 && rd_req && !wr_valid) |=> fill_cnt == '0);

endmodule

bind sample_fifo sample_fifo_chk #(.DEPTH(DEPTH), .CW(CW)) i_chk (
  .clk(clk), .rst_n(rst_n), .cfg_ctrl(cfg_ctrl), .buf_en(buf_en),
  .wr_valid(wr_valid), .rd_req(rd_req), .is_bypass(is_bypass),
  .is_frozen(is_frozen), .is_stream(is_stream), .fill_cnt(fill_cnt),
  .ovr_flag(ovr_flag)
);

// File: tb/test_sample_fifo.sv
`timescale 1ns/1ps
module test_sample_fifo;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  cfg_ctrl = 8'h00;
  logic        buf_en = 1'b1;
  logic [1:0]  trig_in = 2'b00;
  logic        wr_valid = 1'b0;
  logic [15:0] wr_x = '0, wr_y = '0, wr_z = '0;
  logic        rd_req = 1'b0;
  logic [15:0] rd_x, rd_y, rd_z;
  logic        rd_avail;
  logic [7:0]  status;
  logic        wtm_flag, ovr_flag;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  sample_fifo i_sample_fifo (
    .clk(clk), .rst_n(rst_n), .cfg_ctrl(cfg_ctrl), .buf_en(buf_en),
    .trig_in(trig_in), .wr_valid(wr_valid), .wr_x(wr_x), .wr_y(wr_y),
    .wr_z(wr_z), .rd_req(rd_req), .rd_x(rd_x), .rd_y(rd_y), .rd_z(rd_z),
    .rd_avail(rd_avail), .status(status), .wtm_flag(wtm_flag),
    .ovr_flag(ovr_flag)
  );

  // {threshold[4:0], writes[5:0], expected status[7:0]} in stop-when-full mode
  localparam logic [18:0] VEC [8] = '{
    {5'd0,  6'd0,  8'h00},
    {5'd0,  6'd1,  8'h81},
    {5'd4,  6'd4,  8'h04},
    {5'd4,  6'd5,  8'h85},
    {5'd20, 6'd20, 8'h14},
    {5'd31, 6'd31, 8'h1F},
    {5'd31, 6'd32, 8'hBF},
    {5'd10, 6'd33, 8'hFF}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic put(input int k);
    wr_valid = 1'b1;
    wr_x = 16'(k); wr_y = 16'(k + 'h100); wr_z = 16'(k + 'h200);
    tick();
    wr_valid = 1'b0;
  endtask

  task automatic pop1();
    rd_req = 1'b1;
    tick();
    rd_req = 1'b0;
  endtask

  task automatic clear_with(input logic [7:0] ctrl);
    cfg_ctrl = 8'h00;
    tick();
    cfg_ctrl = ctrl;
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    #12;
    // R1 reset state
    check("R1 status", status, 8'h00);
    check("R1 flags", {wtm_flag, ovr_flag}, 2'b00);
    rst_n = 1'b1;
    tick();

    // R3, R9: table of watermark thresholds and fill levels
    for (int i = 0; i < 8; i++) begin
      clear_with({2'b01, 1'b0, VEC[i][18:14]});
      for (int k = 0; k < int'(VEC[i][13:8]); k++) put(k);
      check("R3/R9 status", status, {24'd0, VEC[i][7:0]});
      check("R9 wtm pin", wtm_flag, VEC[i][7]);
    end

    // R6 order in stop-when-full mode (R2 mode field 01)
    clear_with({2'b01, 1'b0, 5'd1});
    put(7); put(8); put(9);
    check("R6 head x", rd_x, 7); check("R6 head y", rd_y, 'h107); check("R6 head z", rd_z, 'h207);
    pop1(); check("R6 second", rd_x, 8);
    check("R9 wtm after read", wtm_flag, 1'b1);
    pop1(); check("R9 wtm drops", wtm_flag, 1'b0);
    pop1(); check("R6 empty avail", rd_avail, 1'b0);

    // R6 refused write when full, R10 read clears overrun
    clear_with({2'b01, 1'b0, 5'd31});
    for (int k = 0; k < 32; k++) put(k);
    put(99);
    check("R6 head kept", rd_x, 0);
    check("R6 overrun", ovr_flag, 1'b1);
    pop1();
    check("R10 overrun cleared", ovr_flag, 1'b0);
    check("R10 count", status, 8'h1F);
    for (int k = 1; k < 31; k++) pop1();
    check("R6 last stored", rd_x, 31);

    // R7 stream discards oldest
    clear_with({2'b10, 1'b0, 5'd31});
    for (int k = 0; k <= 32; k++) put(k);
    check("R7 status", status, 8'hFF);
    check("R7 head advanced", rd_x, 1);

    // R11 write and read together when full
    wr_valid = 1'b1; wr_x = 16'd50; rd_req = 1'b1;
    tick();
    wr_valid = 1'b0; rd_req = 1'b0;
    check("R11 status", status, 8'hBF);
    check("R11 head", rd_x, 2);

    // R12 read while empty
    clear_with({2'b01, 1'b0, 5'd0});
    pop1();
    check("R12 status", status, 8'h00);
    put(3);
    check("R12 after write", status, 8'h81);

    // R8 stream-then-freeze, trigger select bit 5 = 0 -> trig_in[0]
    clear_with({2'b11, 1'b0, 5'd31});
    for (int k = 0; k <= 32; k++) put(k);
    check("R8 streaming drop", rd_x, 1);
    trig_in = 2'b10; tick(); trig_in = 2'b00;
    put(33);
    check("R8 unselected trigger", rd_x, 2);
    trig_in = 2'b01; tick(); trig_in = 2'b00;
    put(34);
    check("R8 frozen head", rd_x, 2);
    check("R8 frozen status", status, 8'hFF);
    cfg_ctrl = {2'b10, 1'b0, 5'd31}; tick();
    cfg_ctrl = {2'b11, 1'b0, 5'd31};
    put(35);
    check("R8 trigger forgotten", rd_x, 3);
    cfg_ctrl = {2'b11, 1'b1, 5'd31};
    trig_in = 2'b10; tick(); trig_in = 2'b00;
    put(36);
    check("R8 select line 1", rd_x, 3);

    // R4 enable low forces bypass
    buf_en = 1'b0;
    put('h55);
    check("R4 pass-through", rd_x, 'h55);
    check("R4 status", status, 8'h00);
    buf_en = 1'b1;

    // R5 bypass mode
    clear_with({2'b01, 1'b0, 5'd0});
    put(1); put(2);
    cfg_ctrl = 8'h00;
    put('h77);
    check("R5 newest set", rd_z, 'h277);
    check("R5 avail", rd_avail, 1'b1);
    check("R5 emptied", status, 8'h00);

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule